// File: doc/BRIEF.md
# Receive Character Queue with Error Status and Level Interrupt

This block sits between a serial receiver and software. Every character the receiver delivers is stored together with four error flags (line break, bad stop bit, parity mismatch, lost data). Software drains the queue through a small register bus. Each read of the data address returns one 12-bit word and removes it from the queue. A separate status address shows the error flags of the word most recently removed. A write of any value to that address wipes those flags.

Two interrupt sources exist: a fill-level source and a lost-character source. The fill-level source is edge-like. It is raised only when an arriving character carries the fill level through a programmable threshold, never merely because the level stays high. Both sources have a raw view, a mask, a masked view and write-one-to-clear. Clearing the queue-enable bit shrinks the queue to one holding slot. A character that arrives with no room is dropped, and its loss is recorded on the newest stored word at once.

Top module: `rx_status_fifo`

## Requirements
- R1: After reset the queue is empty (`fifo_empty`=1, `fifo_full`=0), `irq`=0, raw status, mask and error status read 0, and the config register (address 2) reads 0x5: bit0 queue enable = 1, bits[3:1] threshold select = 2.
- R2: A read of address 0 returns the oldest stored word and removes it. Words leave in arrival order. The word layout is data in bits[7:0], bad stop bit in bit 8, parity error in bit 9, line break in bit 10 and lost-data in bit 11.
- R3: The queue holds at most DEPTH words, or 1 when disabled, and `fifo_full` is 1 at that count. A character that arrives when the queue is full, with no read in the same cycle, is discarded, and bit 11 of the newest stored word becomes 1.
- R4: A discarded character sets bit 3 of the status register (address 1) and raw interrupt bit 1 on the clock edge at which it arrives. It does not wait for any read.
- R5: The status register returns, in bits[2:0], bits[10:8] of the word most recently removed. Its bit 3 is sticky and also picks up bit 11 of removed words.
- R6: A write of any value to address 1 clears all four status bits.
- R7: Raw bit 0 (level) sets when a character is stored while the count equals the threshold T. The threshold select values 0, 1, 2 and 3 give T of 1/8, 1/4, 1/2 and 3/4 of DEPTH, and select values 4 to 7 give 7/8 of DEPTH. With DEPTH=16 and the default select, the 9th character raises it. When the queue is disabled, T=0.
- R8: Once cleared, raw bit 0 stays 0 while further characters arrive with the count already above T.
- R9: A write to address 6 clears each raw bit whose write-data bit is 1. Bits written as 0 are left unchanged.
- R10: Address 3 is the mask (bits[1:0]). Address 5 reads raw AND mask. `irq` is 1 exactly when that AND is non-zero. Address 4 reads raw.
- R11: When a config write changes the enable bit, the queue is emptied. With the queue disabled, one character fills it and the next one is discarded.
- R12: A read of address 0 on an empty queue returns the last word removed. The queue stays empty and no count changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chr_valid | input | 1 | One-cycle strobe: a received character is present |
| chr_data | input | 8 | Received data byte |
| chr_brk | input | 1 | Line break detected for this character |
| chr_frm | input | 1 | Bad stop bit for this character |
| chr_par | input | 1 | Parity mismatch for this character |
| chr_ovr | input | 1 | Receiver-side loss indication stored with the character |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address (0 data, 1 status/clear, 2 config, 3 mask, 4 raw, 5 masked, 6 interrupt clear, 7 flags) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 12 | Read data, valid the cycle after `reg_rd` |
| fifo_empty | output | 1 | Queue holds no word |
| fifo_full | output | 1 | Queue is at its current capacity |
| irq | output | 1 | OR of the masked interrupt bits |

## Verification
A corrupted count shows up quickly. `fifo_full` or `fifo_empty` flips at the wrong character, or the level interrupt fires one character early or late. The data reads then return words out of order, or stale words. A wrong status register or a mis-aimed lost-data mark appears on the very next read of address 1 or on the final word drained. For that reason the bench checks every drained word against its reference queue, and checks the pins after every directed step. A stuck raw bit shows on `irq` in the cycle after the clear write.

// File: rtl/rxq_pkg.sv
// Shared types for the receive character queue.
// Assumes an 8-bit character and four per-character error flags.
package rxq_pkg;
    localparam int BYTE_W  = 8;
    localparam int IRQ_N   = 2;
    localparam int IRQ_LVL = 0;
    localparam int IRQ_OVR = 1;

    typedef struct packed {
        logic ovr;
        logic brk;
        logic par;
        logic frm;
    } rx_err_t;

    typedef struct packed {
        rx_err_t           err;
        logic [BYTE_W-1:0] data;
    } rx_word_t;

    typedef enum logic [2:0] {
        A_DATA = 3'd0,
        A_STAT = 3'd1,
        A_CFG  = 3'd2,
        A_MASK = 3'd3,
        A_RAW  = 3'd4,
        A_MIS  = 3'd5,
        A_ICLR = 3'd6,
        A_FLAG = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/rxq_store.sv
// Circular word store with occupancy count.
// Capacity is DEPTH when enabled and 1 when disabled. Pointers always wrap
// modulo DEPTH, so the disabled mode reuses the same array.
// A character that finds no room is dropped, and the newest word gets its
// lost-data flag set.
// Assumes DEPTH is a power of two and at least 8.
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         fifo_en,
    input  logic                         push_req,
    input  rx_word_t                     push_word,
    input  logic                         pop_req,
    output rx_word_t                     head_word,
    output logic [$clog2(DEPTH):0]       occ,
    output logic                         full,
    output logic                         empty,
    output logic                         push_take,
    output logic                         pop_take,
    output logic                         ovr_evt
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    rx_word_t           mem [DEPTH];
    logic [PTR_W-1:0]   wptr, rptr;
    logic [CNT_W-1:0]   cap;

    // Capacity and handshake decisions for this cycle.
    always_comb begin
        cap       = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
        empty     = (occ == '0);
        full      = (occ == cap);
        pop_take  = pop_req && !empty && !flush;
        push_take = push_req && !flush && (!full || pop_take);
        ovr_evt   = push_req && !flush && !push_take;
        head_word = mem[rptr];
    end

    // Array write: store a new word, or mark the newest one as having lost data.
    always_ff @(posedge clk) begin
        if (push_take) begin
            mem[wptr] <= push_word;
        end else if (ovr_evt) begin
            mem[wptr - PTR_W'(1)].err.ovr <= 1'b1;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr <= '0;
            rptr <= '0;
            occ  <= '0;
        end else begin
            if (push_take) wptr <= wptr + PTR_W'(1);
            if (pop_take)  rptr <= rptr + PTR_W'(1);
            occ <= occ + CNT_W'(push_take) - CNT_W'(pop_take);
        end
    end
endmodule

// File: rtl/rxq_irq.sv
// Interrupt sources: fill-level crossing and dropped character.
// The level source sets only when a stored character moves the count
// through the threshold. Raw bits are sticky until written with 1 at the
// clear address. A set in the same cycle wins over a clear.
module rxq_irq
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fifo_en,
    input  logic [2:0]                trig_sel,
    input  logic [$clog2(DEPTH):0]    occ,
    input  logic                      push_take,
    input  logic                      pop_take,
    input  logic                      ovr_evt,
    input  logic [IRQ_N-1:0]          clr_bits,
    input  logic [IRQ_N-1:0]          mask,
    output logic [IRQ_N-1:0]          raw,
    output logic [IRQ_N-1:0]          masked,
    output logic                      lvl_set,
    output logic                      irq
);
    localparam int CNT_W = $clog2(DEPTH) + 1;

    logic [CNT_W-1:0] thr;
    logic [IRQ_N-1:0] set_bits;

    // Threshold in words for a select code, in eighths of the depth.
    function automatic logic [CNT_W-1:0] thr_of(input logic [2:0] sel);
        int eighths;
        case (sel)
            3'd0:    eighths = 1;
            3'd1:    eighths = 2;
            3'd2:    eighths = 4;
            3'd3:    eighths = 6;
            default: eighths = 7;
        endcase
        return CNT_W'((DEPTH * eighths) / 8);
    endfunction

    // Crossing detection and masked view.
    always_comb begin
        thr                = fifo_en ? thr_of(trig_sel) : '0;
        lvl_set            = push_take && !pop_take && (occ == thr);
        set_bits           = '0;
        set_bits[IRQ_LVL]  = lvl_set;
        set_bits[IRQ_OVR]  = ovr_evt;
        masked             = raw & mask;
        irq                = |masked;
    end

    // Sticky raw status with write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) raw <= '0;
        else        raw <= (raw & ~clr_bits) | set_bits;
    end
endmodule

// File: rtl/rx_status_fifo.sv
// Receive character queue with per-word error flags, a status register
// for the last removed word, and a two-source interrupt.
// Assumes one bus access (read or write) per cycle. Read data is
// registered and valid the cycle after reg_rd.
module rx_status_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        chr_valid,
    input  logic [7:0]  chr_data,
    input  logic        chr_brk,
    input  logic        chr_frm,
    input  logic        chr_par,
    input  logic        chr_ovr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [11:0] reg_rdata,
    output logic        fifo_empty,
    output logic        fifo_full,
    output logic        irq
);
    localparam int CNT_W = $clog2(DEPTH) + 1;

    reg_addr_e           addr_e;
    rx_word_t            in_word, head_word, last_word;
    rx_err_t             stat_q;
    logic                cfg_en;
    logic [2:0]          cfg_trig;
    logic [IRQ_N-1:0]    mask_q, raw_q, mis, clr_bits;
    logic [CNT_W-1:0]    occ;
    logic                push_take, pop_take, ovr_evt, lvl_set;
    logic                flush, pop_req;
    logic [11:0]         rd_next;

    // Decode the bus and pack the incoming character.
    always_comb begin
        addr_e   = reg_addr_e'(reg_addr);
        in_word  = '{err: '{ovr: chr_ovr, brk: chr_brk, par: chr_par, frm: chr_frm},
                     data: chr_data};
        pop_req  = reg_rd && (addr_e == A_DATA);
        flush    = reg_wr && (addr_e == A_CFG) && (reg_wdata[0] != cfg_en);
        clr_bits = (reg_wr && addr_e == A_ICLR) ? reg_wdata[IRQ_N-1:0] : '0;
    end

    rxq_store #(.DEPTH(DEPTH)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .fifo_en   (cfg_en),
        .push_req  (chr_valid),
        .push_word (in_word),
        .pop_req   (pop_req),
        .head_word (head_word),
        .occ       (occ),
        .full      (fifo_full),
        .empty     (fifo_empty),
        .push_take (push_take),
        .pop_take  (pop_take),
        .ovr_evt   (ovr_evt)
    );

    rxq_irq #(.DEPTH(DEPTH)) irq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_en   (cfg_en),
        .trig_sel  (cfg_trig),
        .occ       (occ),
        .push_take (push_take),
        .pop_take  (pop_take),
        .ovr_evt   (ovr_evt),
        .clr_bits  (clr_bits),
        .mask      (mask_q),
        .raw       (raw_q),
        .masked    (mis),
        .lvl_set   (lvl_set),
        .irq       (irq)
    );

    // Configuration and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_en   <= 1'b1;
            cfg_trig <= 3'd2;
            mask_q   <= '0;
        end else if (reg_wr) begin
            if (addr_e == A_CFG) begin
                cfg_en   <= reg_wdata[0];
                cfg_trig <= reg_wdata[3:1];
            end
            if (addr_e == A_MASK) mask_q <= reg_wdata[IRQ_N-1:0];
        end
    end

    // Status of the last removed word, sticky lost-data flag, and the last word itself.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q    <= '0;
            last_word <= '0;
        end else begin
            if (reg_wr && addr_e == A_STAT) stat_q <= '0;
            if (pop_take) begin
                stat_q.frm <= head_word.err.frm;
                stat_q.par <= head_word.err.par;
                stat_q.brk <= head_word.err.brk;
                stat_q.ovr <= stat_q.ovr | head_word.err.ovr;
                last_word  <= head_word;
            end
            if (ovr_evt) stat_q.ovr <= 1'b1;
        end
    end

    // Read-data selection.
    always_comb begin
        case (addr_e)
            A_DATA:  rd_next = pop_take ? head_word : last_word;
            A_STAT:  rd_next = {8'b0, stat_q};
            A_CFG:   rd_next = {8'b0, cfg_trig, cfg_en};
            A_MASK:  rd_next = {10'b0, mask_q};
            A_RAW:   rd_next = {10'b0, raw_q};
            A_MIS:   rd_next = {10'b0, mis};
            A_FLAG:  rd_next = {10'b0, fifo_full, fifo_empty};
            default: rd_next = '0;
        endcase
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_next;
    end
endmodule

// File: rtl/rxq_checker.sv
// Temporal checks on the receive queue, bound into the top module.
module rxq_checker #(
    parameter int DEPTH = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     chr_valid,
    input logic                     reg_wr,
    input logic                     reg_rd,
    input logic [2:0]               reg_addr,
    input logic [7:0]               reg_wdata,
    input logic                     fifo_empty,
    input logic                     fifo_full,
    input logic                     irq,
    input logic [$clog2(DEPTH):0]   occ,
    input logic                     ovr_evt,
    input logic                     lvl_set,
    input logic [1:0]               raw_q,
    input logic [1:0]               mask_q,
    input logic [3:0]               stat_q,
    input logic [11:0]              last_word
);
    localparam int CNT_W = $clog2(DEPTH) + 1;

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));

    p_flags_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_empty && fifo_full));

    p_push_leaves_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_valid && !(reg_wr && reg_addr == 3'd2)) |=> !fifo_empty);

    p_drop_flags_now_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> (stat_q[3] && raw_q[1]));

    p_iclr_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd6 && reg_wdata[0] && !lvl_set) |=> !raw_q[0]);

    p_mask_gates_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 2'b00) |-> !irq);

    p_empty_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 3'd0 && fifo_empty) |=> (last_word == $past(last_word)));
endmodule

bind rx_status_fifo rxq_checker #(.DEPTH(DEPTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .chr_valid  (chr_valid),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .irq        (irq),
    .occ        (occ),
    .ovr_evt    (ovr_evt),
    .lvl_set    (lvl_set),
    .raw_q      (raw_q),
    .mask_q     (mask_q),
    .stat_q     (stat_q),
    .last_word  (last_word)
);

// File: tb/rx_status_fifo_tb_top.sv
// Self-checking bench: directed corners plus seeded random traffic
// against a queue-based reference model.
module rx_status_fifo_tb_top;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chr_valid = 1'b0;
    logic [7:0]  chr_data = '0;
    logic        chr_brk = 1'b0, chr_frm = 1'b0, chr_par = 1'b0, chr_ovr = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [11:0] reg_rdata;
    logic        fifo_empty, fifo_full, irq;

    int n_run = 0;
    int n_fail = 0;

    // Reference model state.
    logic [11:0] q[$];
    bit          m_en = 1'b1;
    bit [2:0]    m_trig = 3'd2;
    bit [1:0]    m_raw = '0, m_mask = '0;
    bit [3:0]    m_stat = '0;
    logic [11:0] m_last = '0;

    always #4 clk = ~clk;

    rx_status_fifo #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .chr_valid(chr_valid), .chr_data(chr_data),
        .chr_brk(chr_brk), .chr_frm(chr_frm), .chr_par(chr_par), .chr_ovr(chr_ovr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .fifo_empty(fifo_empty), .fifo_full(fifo_full), .irq(irq)
    );

    function automatic int m_cap();
        return m_en ? DEPTH : 1;
    endfunction

    function automatic int m_thr();
        int e;
        case (m_trig)
            3'd0: e = 1; 3'd1: e = 2; 3'd2: e = 4; 3'd3: e = 6;
            default: e = 7;
        endcase
        return m_en ? (DEPTH * e) / 8 : 0;
    endfunction

    function automatic logic [11:0] m_peek(input logic [2:0] a);
        case (a)
            3'd0: return (q.size() > 0) ? q[0] : m_last;
            3'd1: return {8'b0, m_stat};
            3'd2: return {8'b0, m_trig, m_en};
            3'd3: return {10'b0, m_mask};
            3'd4: return {10'b0, m_raw};
            3'd5: return {10'b0, m_raw & m_mask};
            3'd7: return {10'b0, q.size() == m_cap(), q.size() == 0};
            default: return 12'h000;
        endcase
    endfunction

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%03h expected=0x%03h", tag, act, exp);
        end
    endtask

    task automatic chk_pins(input string tag);
        check(tag, {9'b0, irq, fifo_full, fifo_empty},
              {9'b0, |(m_raw & m_mask), q.size() == m_cap(), q.size() == 0});
    endtask

    task automatic rx_char(input logic [7:0] d, input logic [3:0] e);
        chr_valid = 1'b1;
        chr_data  = d;
        {chr_ovr, chr_brk, chr_par, chr_frm} = e;
        @(negedge clk);
        chr_valid = 1'b0;
        if (q.size() < m_cap()) begin
            if (q.size() == m_thr()) m_raw[0] = 1'b1;
            q.push_back({e, d});
        end else begin
            q[q.size()-1][11] = 1'b1;
            m_stat[3] = 1'b1;
            m_raw[1]  = 1'b1;
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        case (a)
            3'd1: m_stat = '0;
            3'd2: begin
                if (d[0] != m_en) q.delete();
                m_en = d[0]; m_trig = d[3:1];
            end
            3'd3: m_mask = d[1:0];
            3'd6: m_raw = m_raw & ~d[1:0];
            default: ;
        endcase
    endtask

    task automatic chk_rd(input logic [2:0] a, input string tag);
        logic [11:0] exp;
        exp = m_peek(a);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        check(tag, reg_rdata, exp);
        if (a == 3'd0 && q.size() > 0) begin
            m_last = q.pop_front();
            m_stat = {m_stat[3] | m_last[11], m_last[10:8]};
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk_pins("R1 pins after reset");
        chk_rd(3'd2, "R1 config reset");
        chk_rd(3'd4, "R1 raw reset");
        chk_rd(3'd1, "R1 status reset");

        // R7: default threshold fires on the 9th character
        for (int i = 0; i < 8; i++) rx_char(8'h10 + 8'(i), 4'b0000);
        chk_rd(3'd4, "R7 raw quiet after 8 chars");
        rx_char(8'h18, 4'b0001);
        chk_rd(3'd4, "R7 raw set on 9th char");
        // R10: mask routes to irq and masked view
        chk_pins("R10 irq low while unmasked");
        bus_wr(3'd3, 8'h01);
        chk_pins("R10 irq follows mask");
        chk_rd(3'd5, "R10 masked view");
        // R9: zero write leaves raw, one write clears
        bus_wr(3'd6, 8'h00);
        chk_rd(3'd4, "R9 zero write no effect");
        bus_wr(3'd6, 8'h01);
        chk_rd(3'd4, "R9 one write clears");
        chk_pins("R9 irq drops after clear");
        // R8: no re-fire while above threshold
        rx_char(8'h19, 4'b0010);
        chk_rd(3'd4, "R8 no refire above level");

        // R3/R4: fill then drop
        for (int i = 10; i < DEPTH; i++) rx_char(8'h10 + 8'(i), 4'b0000);
        chk_pins("R3 full at depth");
        bus_wr(3'd3, 8'h03);
        rx_char(8'hEE, 4'b0100);
        chk_rd(3'd1, "R4 status lost flag immediate");
        chk_rd(3'd4, "R4 raw lost flag");
        chk_pins("R3 still full after drop");
        // R2/R5: drain in order, status follows removed word
        for (int i = 0; i < DEPTH; i++) begin
            chk_rd(3'd0, "R2 data order");
            if (i == 9) chk_rd(3'd1, "R5 status of removed word");
        end
        chk_rd(3'd1, "R5 status after last word (R3 mark)");
        // R12: empty read returns last word
        chk_rd(3'd0, "R12 empty read last word");
        chk_pins("R12 still empty");
        // R6: any write clears status
        bus_wr(3'd1, 8'h5A);
        chk_rd(3'd1, "R6 status cleared");
        bus_wr(3'd6, 8'h03);

        // R7: threshold select 0 -> 3rd char fires
        bus_wr(3'd2, 8'h01);
        rx_char(8'hA1, 4'b0000);
        rx_char(8'hA2, 4'b0000);
        chk_rd(3'd4, "R7 sel0 quiet at 2");
        rx_char(8'hA3, 4'b0000);
        chk_rd(3'd4, "R7 sel0 fires at 3");
        bus_wr(3'd6, 8'h03);

        // R11: disable flushes, single slot, second char dropped
        bus_wr(3'd2, 8'h04);
        chk_pins("R11 flushed on disable");
        rx_char(8'hB1, 4'b0000);
        chk_pins("R11 full after one");
        chk_rd(3'd4, "R11 level fires at zero threshold");
        rx_char(8'hB2, 4'b0000);
        chk_rd(3'd0, "R11 held word carries lost flag");
        bus_wr(3'd2, 8'h05);
        bus_wr(3'd6, 8'h03);
        bus_wr(3'd1, 8'h00);

        // Random traffic against the model (R2 R3 R5 R7 R9 R10).
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = int'($urandom_range(0, 19));
            if (r < 10) rx_char(8'($urandom), ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'b0000);
            else if (r < 16) chk_rd(3'd0, "R2 random data");
            else if (r == 16) begin chk_rd(3'd4, "R7 random raw"); chk_pins("R3 random pins"); end
            else if (r == 17) chk_rd(3'd1, "R5 random status");
            else if (r == 18) bus_wr(3'd6, 8'($urandom_range(0, 3)));
            else bus_wr(3'd2, {4'b0, 3'($urandom), 1'b1});
        end
        while (q.size() > 0) chk_rd(3'd0, "R2 final drain");
        chk_pins("R10 final pins");

        summary();
    end
endmodule